// File: doc/BRIEF.md
# Resonant Converter Soft-Start PWM Sequencer

This block produces the raw gate pattern for the two switches of a half-bridge while a resonant converter starts up, and then settles into steady symmetrical switching. An up-counting time base runs from zero to a fixed top value and wraps, and each wrap opens a new switching cycle. A short built-in schedule gives every early cycle its own output setting. The first cycle turns on only the low-side switch, and the second keeps both switches off. The next two cycles switch the pair complementarily with a short and then a longer high-side pulse. From the fifth cycle onward the pair switches at the half-period compare value for as long as the sequencer runs.

Each cycle's setting is prepared in a shadow copy and committed to the active set as a whole on the same clock edge at which the counter returns to zero. A cycle therefore never mixes settings from two steps. A start strobe launches the schedule from its first step. A trip input stops everything: both outputs fall on the next clock edge and the block waits for a new start strobe. Dead-time insertion is done by a stage downstream of the two phase outputs.

Top module: `resonant_softstart_pwm`

## Requirements
- R1: After reset and until the first start strobe, both phase outputs are low, the cycle-start pulse is low and the step index reads 0.
- R2: A start strobe that is sampled while idle makes the next clock cycle the first cycle of step 0, with the cycle-start pulse high. A start strobe that arrives while the sequencer is running has no effect on the outputs or on the timing.
- R3: While the sequencer runs, the counter goes 0,1,…,PERIOD_TOP and then back to 0, so with the default PERIOD_TOP of 1200 each cycle lasts 1201 clocks. The cycle-start pulse is high for exactly the one clock in which the counter is 0.
- R4: Step 0 (step index 0): phase B, the low side, is high for the whole cycle and phase A, the high side, is low for the whole cycle.
- R5: Step 1 (step index 1): both outputs are low for the whole cycle.
- R6: In the complementary steps, phase A is high while the counter is below the step's compare value and phase B is high for the rest of the cycle. Step 2 uses compare value 150, so A is high for 150 clocks and B for 1051 clocks.
- R7: Step 3 uses compare value 450, so A is high for 450 clocks and B for 751 clocks.
- R8: Step 4 uses the half compare value 600, so A is high for 600 clocks and B for 601 clocks. The step index saturates at 4 and every later cycle repeats step 4.
- R9: Period, compare selection and output forcing change only together at a cycle boundary. The step index changes only in a clock in which the cycle-start pulse is high, or after a trip.
- R10: The two phase outputs are never high at the same time.
- R11: While the trip input is sampled high, both outputs, the cycle-start pulse and the step index read 0 from the next clock on. Trip takes priority over a start strobe. After a trip, the sequencer stays idle until a new start strobe, which restarts the schedule at step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; launches the schedule when idle |
| trip_i | input | 1 | Trip; forces outputs low and returns to idle |
| phase_a_o | output | 1 | High-side raw PWM |
| phase_b_o | output | 1 | Low-side raw PWM |
| cyc_start_o | output | 1 | One-clock pulse while the counter is zero |
| step_o | output | 3 | Index of the step currently on the outputs (0..4) |

## Verification
A complete startup from reset is run through six cycles. Measuring the high time of each phase per cycle tells the single-side, all-off, narrow, wide and half-duty steps apart, and a repeated fifth-step cycle shows saturation. A start strobe placed in the middle of a running cycle shows that the period is not restarted. A trip raised mid-cycle together with a start strobe shows the one-clock shutdown and that trip takes priority. A final restart shows that the schedule begins again at its first step rather than at the step that was interrupted.

// File: rtl/rss_pkg.sv
package rss_pkg;

   localparam int STEP_CNT  = 5;
   localparam int STEP_W    = $clog2(STEP_CNT);
   localparam int LAST_STEP = STEP_CNT - 1;

   // per-phase drive mode of a step
   typedef enum logic [1:0] {
      DRV_OFF = 2'd0,
      DRV_ON  = 2'd1,
      DRV_PWM = 2'd2
   } drv_e;

   // which compare value a step uses
   typedef enum logic [1:0] {
      SEL_NARROW = 2'd0,
      SEL_WIDE   = 2'd1,
      SEL_HALF   = 2'd2
   } cmp_sel_e;

   typedef struct packed {
      drv_e     hs;
      drv_e     ls;
      cmp_sel_e sel;
   } step_cfg_t;

   localparam step_cfg_t IDLE_CFG = '{hs: DRV_OFF, ls: DRV_OFF, sel: SEL_HALF};

   // startup schedule, one entry per step
   function automatic step_cfg_t cfg_of(input logic [STEP_W-1:0] idx);
      step_cfg_t c;
      case (idx)
         STEP_W'(0): c = '{hs: DRV_OFF, ls: DRV_ON,  sel: SEL_HALF};
         STEP_W'(1): c = '{hs: DRV_OFF, ls: DRV_OFF, sel: SEL_HALF};
         STEP_W'(2): c = '{hs: DRV_PWM, ls: DRV_PWM, sel: SEL_NARROW};
         STEP_W'(3): c = '{hs: DRV_PWM, ls: DRV_PWM, sel: SEL_WIDE};
         default:    c = '{hs: DRV_PWM, ls: DRV_PWM, sel: SEL_HALF};
      endcase
      return c;
   endfunction

   function automatic logic [STEP_W-1:0] next_idx(input logic [STEP_W-1:0] idx);
      return (idx == STEP_W'(LAST_STEP)) ? idx : idx + STEP_W'(1);
   endfunction

endpackage

// File: rtl/rss_timebase.sv
module rss_timebase #(
   parameter int PERIOD_TOP = 1200,
   parameter int CNT_W      = $clog2(PERIOD_TOP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             trip_i,
   output logic             load_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             cyc_start_o
);

   localparam logic [CNT_W-1:0] TOP_C = CNT_W'(PERIOD_TOP);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   always_comb begin
      wrap   = run_q && (cnt_q == TOP_C);
      load_o = !trip_i && ((!run_q && start_i) || wrap);
      if (trip_i || load_o || !run_q)
         cnt_nxt_o = '0;
      else
         cnt_nxt_o = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         cnt_q       <= '0;
         cyc_start_o <= 1'b0;
      end else begin
         if (trip_i)
            run_q <= 1'b0;
         else if (load_o)
            run_q <= 1'b1;
         cnt_q       <= cnt_nxt_o;
         cyc_start_o <= load_o;
      end
   end

endmodule

// File: rtl/rss_step_sched.sv
module rss_step_sched
   import rss_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              trip_i,
   output step_cfg_t         cfg_nxt_o,
   output logic [STEP_W-1:0] step_o
);

   logic [STEP_W-1:0] pend_q;
   step_cfg_t         shadow_q;
   step_cfg_t         active_q;

   // the whole shadow set becomes active on the wrap edge
   always_comb begin
      if (trip_i)
         cfg_nxt_o = IDLE_CFG;
      else if (load_i)
         cfg_nxt_o = shadow_q;
      else
         cfg_nxt_o = active_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= '0;
         shadow_q <= cfg_of('0);
         active_q <= IDLE_CFG;
         step_o   <= '0;
      end else begin
         active_q <= cfg_nxt_o;
         if (trip_i) begin
            pend_q   <= '0;
            shadow_q <= cfg_of('0);
            step_o   <= '0;
         end else if (load_i) begin
            step_o   <= pend_q;
            pend_q   <= next_idx(pend_q);
            shadow_q <= cfg_of(next_idx(pend_q));
         end
      end
   end

endmodule

// File: rtl/rss_phase_lane.sv
module rss_phase_lane
   import rss_pkg::*;
#(
   parameter int CNT_W      = 11,
   parameter bit COMPLEMENT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  drv_e             drv_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   output logic             out_o
);

   logic pwm_raw;
   logic out_nxt;

   generate
      if (COMPLEMENT) begin : g_tail
         assign pwm_raw = (cnt_nxt_i >= cmp_i);
      end else begin : g_head
         assign pwm_raw = (cnt_nxt_i < cmp_i);
      end
   endgenerate

   always_comb begin
      case (drv_i)
         DRV_ON:  out_nxt = 1'b1;
         DRV_PWM: out_nxt = pwm_raw;
         default: out_nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         out_o <= 1'b0;
      else
         out_o <= out_nxt;
   end

endmodule

// File: rtl/resonant_softstart_pwm.sv
module resonant_softstart_pwm
   import rss_pkg::*;
#(
   parameter int PERIOD_TOP = 1200,
   parameter int CMP_NARROW = 150,
   parameter int CMP_WIDE   = 450,
   parameter int CMP_HALF   = PERIOD_TOP / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              trip_i,
   output logic              phase_a_o,
   output logic              phase_b_o,
   output logic              cyc_start_o,
   output logic [STEP_W-1:0] step_o
);

   localparam int CNT_W = $clog2(PERIOD_TOP + 1);
   localparam logic [CNT_W-1:0] CMP_N_C = CNT_W'(CMP_NARROW);
   localparam logic [CNT_W-1:0] CMP_W_C = CNT_W'(CMP_WIDE);
   localparam logic [CNT_W-1:0] CMP_H_C = CNT_W'(CMP_HALF);

   generate
      if (PERIOD_TOP < 4) begin : g_bad_top
         $error("PERIOD_TOP must be at least 4");
      end
      if (CMP_NARROW < 1 || CMP_NARROW >= CMP_WIDE) begin : g_bad_narrow
         $error("CMP_NARROW must be positive and below CMP_WIDE");
      end
      if (CMP_WIDE > CMP_HALF || CMP_HALF > PERIOD_TOP) begin : g_bad_half
         $error("compare values must rise up to CMP_HALF within the period");
      end
   endgenerate

   logic             load;
   logic [CNT_W-1:0] cnt_nxt;
   step_cfg_t        cfg_nxt;
   logic [CNT_W-1:0] cmp_nxt;
   logic [1:0]       lane_out;

   rss_timebase #(
      .PERIOD_TOP (PERIOD_TOP),
      .CNT_W      (CNT_W)
   ) u_tb (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .trip_i      (trip_i),
      .load_o      (load),
      .cnt_nxt_o   (cnt_nxt),
      .cyc_start_o (cyc_start_o)
   );

   rss_step_sched u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .trip_i    (trip_i),
      .cfg_nxt_o (cfg_nxt),
      .step_o    (step_o)
   );

   always_comb begin
      case (cfg_nxt.sel)
         SEL_NARROW: cmp_nxt = CMP_N_C;
         SEL_WIDE:   cmp_nxt = CMP_W_C;
         default:    cmp_nxt = CMP_H_C;
      endcase
   end

   // lane 0 = high side (leading), lane 1 = low side (trailing)
   for (genvar g = 0; g < 2; g++) begin : g_lane
      drv_e drv;
      if (g == 0) begin : g_hs
         assign drv = cfg_nxt.hs;
      end else begin : g_ls
         assign drv = cfg_nxt.ls;
      end
      rss_phase_lane #(
         .CNT_W      (CNT_W),
         .COMPLEMENT (g == 1)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .drv_i     (drv),
         .cmp_i     (cmp_nxt),
         .cnt_nxt_i (cnt_nxt),
         .out_o     (lane_out[g])
      );
   end

   assign phase_a_o = lane_out[0];
   assign phase_b_o = lane_out[1];

endmodule

// File: rtl/rss_checker.sv
module rss_checker
   import rss_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              trip_i,
   input logic              phase_a_o,
   input logic              phase_b_o,
   input logic              cyc_start_o,
   input logic [STEP_W-1:0] step_o
);

   // R10
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(phase_a_o && phase_b_o));

   // R11
   trip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_i |=> (!phase_a_o && !phase_b_o && !cyc_start_o && step_o == '0));

   // R3
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |=> !cyc_start_o);

   // R9
   step_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trip_i |=> (cyc_start_o || $stable(step_o)));

   // R8
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_o <= STEP_W'(LAST_STEP));

   // R5
   off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o == STEP_W'(1)) |-> (!phase_a_o && !phase_b_o));

   // R4
   low_side_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o == '0 && cyc_start_o) |-> (phase_b_o && !phase_a_o));

   // R2
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !trip_i && !cyc_start_o && step_o == STEP_W'(LAST_STEP)) |=> !cyc_start_o);

endmodule

bind resonant_softstart_pwm rss_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .trip_i      (trip_i),
   .phase_a_o   (phase_a_o),
   .phase_b_o   (phase_b_o),
   .cyc_start_o (cyc_start_o),
   .step_o      (step_o)
);

// File: tb/resonant_softstart_pwm_tb.sv
`timescale 1ns/1ps
module resonant_softstart_pwm_tb;

   localparam int TOP = 1200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       trip = 1'b0;
   logic       pa, pb, cs;
   logic [2:0] step;

   int n_chk = 0, n_fail = 0;
   int mm_chk = 0, mm_fail = 0;
   bit wd_fail = 0;

   always #2.5 clk = ~clk;

   resonant_softstart_pwm u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .trip_i      (trip),
      .phase_a_o   (pa),
      .phase_b_o   (pb),
      .cyc_start_o (cs),
      .step_o      (step)
   );

   // behavioural reference model
   int m_run = 0, m_cnt = 0, m_step = 0, m_pend = 0;
   bit m_a = 0, m_b = 0, m_cs = 0;

   function automatic void model_outs();
      int cmp;
      case (m_step)
         0: begin m_a = 0; m_b = 1; end
         1: begin m_a = 0; m_b = 0; end
         default: begin
            cmp = (m_step == 2) ? 150 : (m_step == 3) ? 450 : 600;
            m_a = (m_cnt < cmp);
            m_b = !m_a;
         end
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n || trip) begin
         m_run = 0; m_cnt = 0; m_step = 0; m_pend = 0;
         m_a = 0; m_b = 0; m_cs = 0;
      end else if ((m_run == 0 && start) || (m_run == 1 && m_cnt == TOP)) begin
         m_run = 1; m_cnt = 0; m_step = m_pend;
         if (m_pend < 4) m_pend++;
         m_cs = 1;
         model_outs();
      end else if (m_run == 1) begin
         m_cnt++; m_cs = 0;
         model_outs();
      end else begin
         m_cs = 0; m_a = 0; m_b = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         mm_chk++;
         if (pa !== m_a || pb !== m_b || cs !== m_cs || step !== 3'(m_step)) begin
            mm_fail++;
            $display("FAIL R3/model mismatch t=%0t actual a=%0d b=%0d cs=%0d step=%0d expected a=%0d b=%0d cs=%0d step=%0d",
                     $time, pa, pb, cs, step, m_a, m_b, m_cs, m_step);
         end
      end
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a negedge with cs high; ends at the next cycle start
   task automatic measure(input string tag, input int exp_step, input int exp_a, input int exp_b);
      int na = 0, nb = 0, ncs = 0, bad_step = 0;
      for (int i = 0; i <= TOP; i++) begin
         na += int'(pa); nb += int'(pb); ncs += int'(cs);
         if (step != 3'(exp_step)) bad_step++;
         @(negedge clk);
      end
      check_eq({tag, " phase A high clocks"}, na, exp_a);
      check_eq({tag, " phase B high clocks"}, nb, exp_b);
      check_eq({tag, " step index steady"}, bad_step, 0);
      check_eq("R3 one pulse per cycle", ncs, 1);
      check_eq("R3 next cycle starts after 1201 clocks", int'(cs), 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check_eq("R1 reset phase A", int'(pa), 0);
      check_eq("R1 reset phase B", int'(pb), 0);
      check_eq("R1 reset pulse", int'(cs), 0);
      check_eq("R1 reset step", int'(step), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_eq("R1 idle without start", int'(pa | pb | cs), 0);

      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_eq("R2 start gives pulse", int'(cs), 1);
      check_eq("R2 start at step 0", int'(step), 0);

      measure("R4 step0", 0, 0, 1201);
      measure("R5 step1", 1, 0, 0);
      measure("R6 step2", 2, 150, 1051);
      measure("R7 step3", 3, 450, 751);
      measure("R8 step4", 4, 600, 601);
      measure("R8 saturated", 4, 600, 601);

      // start strobe mid-cycle must not restart the period
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      begin
         int early = 0;
         for (int i = 0; i < TOP + 1 - 301; i++) begin
            early += int'(cs);
            @(negedge clk);
         end
         check_eq("R2 running start ignored no early pulse", early, 0);
         check_eq("R2 running start ignored pulse on time", int'(cs), 1);
         check_eq("R8 step stays 4", int'(step), 4);
      end

      // trip mid-cycle, with start held alongside
      repeat (100) @(negedge clk);
      check_eq("R6 phase A high early in cycle", int'(pa), 1);
      trip = 1'b1;
      start = 1'b1;
      @(negedge clk);
      check_eq("R11 trip phase A low", int'(pa), 0);
      check_eq("R11 trip phase B low", int'(pb), 0);
      check_eq("R11 trip step 0", int'(step), 0);
      repeat (3) @(negedge clk);
      check_eq("R11 trip beats start", int'(pa | pb | cs), 0);
      trip = 1'b0;
      start = 1'b0;
      begin
         int act = 0;
         for (int i = 0; i < 10; i++) begin
            act += int'(pa | pb | cs);
            @(negedge clk);
         end
         check_eq("R11 stays idle after trip", act, 0);
      end

      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_eq("R11 restart pulse", int'(cs), 1);
      check_eq("R11 restart at step 0", int'(step), 0);
      measure("R11 restart step0", 0, 0, 1201);
      measure("R5 restart step1", 1, 0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk + mm_chk, n_fail + mm_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      wd_fail = 1;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk + mm_chk + 1, n_fail + mm_fail + 1);
      $finish;
   end

endmodule